// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block decodes the bus write cycles that a host sends to one bank of a NOR-style flash memory and recognises the command sequences that start an erase. Each write arrives as a one-cycle strobe with an address and a data byte. The block follows the unlock-prefixed sequences for whole-bank erase and for sector erase. It also follows the shorter forms that apply once the bank has been placed in unlock-bypass mode. When a sequence is malformed, the decoder drops back to read mode.

A sector erase opens an acceptance window, whose length is a parameter in microseconds scaled by the clock frequency. While the window is open, the host may name further sectors. Each new sector adds one bit to a 64-entry sector bitmap and restarts the window. Any other command closes the window and discards the request, except a suspend request, which is forwarded as a pulse. When the window lapses, the block issues a one-cycle erase request together with the bitmap. It then stays busy until the array reports completion. A status bit shows that the window has run out and sector erasing is under way.

Top module: `erase_cmd_seq`

## Requirements
- R1: After reset, erase_start, erase_busy, erase_chip, timer_expired, suspend_req and bypass_mode are all 0, and erase_map is all zeros.
- R2: The normal sector erase uses six strobes: 0xAA at low address 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 with the sector number in address bits [17:12]. erase_start is high for exactly one cycle, in the cycle that follows the clock edge lying WIN_US*CLK_MHZ edges after the edge that sampled the last strobe. At that moment erase_map has only the bit of that sector set.
- R3: While the window is open, each further 0x30 strobe sets the bit of its own sector and restarts the full window from that strobe.
- R4: While the window is open, a strobe whose data is neither 0x30 nor 0xB0 cancels the request. No erase_start follows, erase_map clears, and the decoder returns to read mode, where a new sequence is accepted.
- R5: A 0xB0 strobe during the window does not cancel the request and does not restart the window. It gives a one-cycle suspend_req pulse in the cycle after the strobe. A 0xB0 strobe during sector erasing gives the same pulse.
- R6: The normal chip erase uses six strobes: the first five are the same as in R2, and the sixth is 0x10 at 0x555. erase_start rises in the cycle right after the last strobe, with erase_chip high and erase_map all ones.
- R7: erase_busy stays high from erase_start until an erase_done pulse. While it is high, strobes leave the bitmap and busy state unchanged. During chip erase, 0xB0 also gives no suspend_req. When erase_done arrives, busy, erase_chip and the bitmap clear.
- R8: The strobes 0xAA at 0x555, 0x55 at 0x2AA, then 0x20 at 0x555 set bypass_mode. In bypass mode, chip erase is 0x80 then 0x10 (two strobes, address ignored). Sector erase is 0x80, 0xAA at 0x555, 0x55 at 0x2AA, then the sector address with 0x30 (four strobes). Completing an erase does not clear bypass_mode.
- R9: In bypass mode, 0x90 followed by 0x00 clears bypass_mode. 0x90 followed by any other byte leaves it set. After exit, the two-strobe chip erase no longer starts anything.
- R10: A strobe that does not match the expected unlock address and data returns the decoder to idle. The strobes that follow must then begin a sequence again from the first unlock cycle.
- R11: timer_expired is 0 while the window is open. It is 1 from the cycle of a sector erase_start until erase_done, and it stays 0 during chip erase.
- R12: Asserting rst_n low at any time ends an erase in progress at once. Busy, the bitmap, erase_chip and bypass_mode all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_stb | input | 1 | One-cycle write strobe (end of a host write pulse) |
| wr_addr | input | 18 | Write address; bits [11:0] checked for unlock, bits [17:12] give the sector |
| wr_data | input | 8 | Write data byte (command code) |
| erase_done | input | 1 | Completion pulse from the array |
| erase_start | output | 1 | One-cycle erase request |
| erase_map | output | 64 | Bitmap of sectors to erase, valid while busy |
| erase_chip | output | 1 | Current erase covers the whole bank |
| erase_busy | output | 1 | Erase in progress |
| timer_expired | output | 1 | Acceptance window ran out; sector erase under way |
| suspend_req | output | 1 | One-cycle suspend request forwarded to the erase engine |
| bypass_mode | output | 1 | Unlock-bypass mode active |

## Verification
The assertions assume that wr_stb is a single-cycle pulse and is never held across back-to-back edges as one write. They also assume that erase_done arrives only while the block is busy, as the array would send it. The bench drives every strobe through one write task. That task raises wr_stb for exactly one clock, with the address and data steady around the sampling edge. The bench pulses erase_done only after it has seen erase_busy high. It never pulses erase_done during the acceptance window, so the timing of the window stays visible at the ports.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_SETUP, S_SUNL1, S_SUNL2,
    S_BSETUP, S_BEXIT, S_WINDOW, S_SECT_ERASE, S_CHIP_ERASE
  } seq_state_e;

  localparam logic [7:0]  CMD_KEY_A    = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_SETUP    = 8'h80;
  localparam logic [7:0]  CMD_CHIP     = 8'h10;
  localparam logic [7:0]  CMD_SECTOR   = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0]  CMD_BYP_ON   = 8'h20;
  localparam logic [7:0]  CMD_BYP_OFF1 = 8'h90;
  localparam logic [7:0]  CMD_BYP_OFF2 = 8'h00;
  localparam logic [11:0] ADR_KEY_A    = 12'h555;
  localparam logic [11:0] ADR_KEY_B    = 12'h2AA;

  // one bus cycle matches an expected address/data pair
  function automatic logic cycle_is(input logic [11:0] adr, input logic [7:0] dat,
                                    input logic [11:0] want_adr, input logic [7:0] want_dat);
    return (adr == want_adr) && (dat == want_dat);
  endfunction

  // acceptance window length in clock cycles
  function automatic int window_cycles(input int us, input int mhz);
    return us * mhz;
  endfunction

endpackage

// File: rtl/window_timer.sv
module window_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart)              cnt <= '0;
    else if (run && cnt != LAST)   cnt <= cnt + CW'(1);
  end

  assign expired = (cnt == LAST);

  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/sector_bitmap.sv
module sector_bitmap #(
  parameter int SECTORS = 64,
  localparam int SW = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               fill,
  input  logic               set,
  input  logic [SW-1:0]      idx,
  output logic [SECTORS-1:0] map
);

  for (genvar i = 0; i < SECTORS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             map[i] <= 1'b0;
      else if (clr)                           map[i] <= 1'b0;
      else if (fill)                          map[i] <= 1'b1;
      else if (set && idx == SW'(i))          map[i] <= 1'b1;
    end
  end

  p_set_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr && !fill) |=> map[$past(idx)]);
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (map == '0));

endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int SECTORS = 64,
  parameter int WIN_US  = 50,
  parameter int CLK_MHZ = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               erase_done,
  output logic               erase_start,
  output logic [SECTORS-1:0] erase_map,
  output logic               erase_chip,
  output logic               erase_busy,
  output logic               timer_expired,
  output logic               suspend_req,
  output logic               bypass_mode
);
  localparam int SW      = $clog2(SECTORS);
  localparam int WIN_CYC = window_cycles(WIN_US, CLK_MHZ);

  seq_state_e st, st_nxt;
  logic       byp, byp_nxt;
  logic       start_q, chip_q, susp_q;

  // named internal events
  logic          ev_accept, ev_chip, ev_sect_go, ev_abort, ev_susp, ev_done;
  logic          win_expired;
  logic [11:0]   adr_lo;
  logic [SW-1:0] sect_idx;

  assign adr_lo   = wr_addr[11:0];
  assign sect_idx = wr_addr[ADDR_W-1 -: SW];

  always_comb begin
    st_nxt     = st;
    byp_nxt    = byp;
    ev_accept  = 1'b0;
    ev_chip    = 1'b0;
    ev_sect_go = 1'b0;
    ev_abort   = 1'b0;
    ev_susp    = 1'b0;
    ev_done    = 1'b0;
    unique case (st)
      S_IDLE: if (wr_stb) begin
        if (byp) begin
          if (wr_data == CMD_SETUP)         st_nxt = S_BSETUP;
          else if (wr_data == CMD_BYP_OFF1) st_nxt = S_BEXIT;
        end else if (cycle_is(adr_lo, wr_data, ADR_KEY_A, CMD_KEY_A)) begin
          st_nxt = S_UNL1;
        end
      end
      S_UNL1: if (wr_stb)
        st_nxt = cycle_is(adr_lo, wr_data, ADR_KEY_B, CMD_KEY_B) ? S_UNL2 : S_IDLE;
      S_UNL2: if (wr_stb) begin
        st_nxt = S_IDLE;
        if (cycle_is(adr_lo, wr_data, ADR_KEY_A, CMD_SETUP))       st_nxt = S_SETUP;
        else if (cycle_is(adr_lo, wr_data, ADR_KEY_A, CMD_BYP_ON)) byp_nxt = 1'b1;
      end
      S_SETUP: if (wr_stb)
        st_nxt = cycle_is(adr_lo, wr_data, ADR_KEY_A, CMD_KEY_A) ? S_SUNL1 : S_IDLE;
      S_SUNL1: if (wr_stb)
        st_nxt = cycle_is(adr_lo, wr_data, ADR_KEY_B, CMD_KEY_B) ? S_SUNL2 : S_IDLE;
      S_SUNL2: if (wr_stb) begin
        if (wr_data == CMD_SECTOR) begin
          ev_accept = 1'b1;
          st_nxt    = S_WINDOW;
        end else if (cycle_is(adr_lo, wr_data, ADR_KEY_A, CMD_CHIP)) begin
          ev_chip = 1'b1;
          st_nxt  = S_CHIP_ERASE;
        end else begin
          st_nxt = S_IDLE;
        end
      end
      S_BSETUP: if (wr_stb) begin
        if (wr_data == CMD_CHIP) begin
          ev_chip = 1'b1;
          st_nxt  = S_CHIP_ERASE;
        end else if (cycle_is(adr_lo, wr_data, ADR_KEY_A, CMD_KEY_A)) begin
          st_nxt = S_SUNL1;
        end else begin
          st_nxt = S_IDLE;
        end
      end
      S_BEXIT: if (wr_stb) begin
        if (wr_data == CMD_BYP_OFF2) byp_nxt = 1'b0;
        st_nxt = S_IDLE;
      end
      S_WINDOW: begin
        if (wr_stb && wr_data == CMD_SECTOR) begin
          ev_accept = 1'b1;
        end else if (wr_stb && wr_data != CMD_SUSPEND) begin
          ev_abort = 1'b1;
          st_nxt   = S_IDLE;
        end else begin
          ev_susp = wr_stb;
          if (win_expired) begin
            ev_sect_go = 1'b1;
            st_nxt     = S_SECT_ERASE;
          end
        end
      end
      S_SECT_ERASE: begin
        ev_susp = wr_stb && (wr_data == CMD_SUSPEND);
        if (erase_done) begin
          ev_done = 1'b1;
          st_nxt  = S_IDLE;
        end
      end
      S_CHIP_ERASE: if (erase_done) begin
        ev_done = 1'b1;
        st_nxt  = S_IDLE;
      end
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      byp     <= 1'b0;
      start_q <= 1'b0;
      chip_q  <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      st      <= st_nxt;
      byp     <= byp_nxt;
      start_q <= ev_chip | ev_sect_go;
      susp_q  <= ev_susp;
      if (ev_done)      chip_q <= 1'b0;
      else if (ev_chip) chip_q <= 1'b1;
    end
  end

  window_timer #(.LIMIT(WIN_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ev_accept),
    .run     (st == S_WINDOW),
    .expired (win_expired)
  );

  sector_bitmap #(.SECTORS(SECTORS)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_abort | ev_done),
    .fill  (ev_chip),
    .set   (ev_accept),
    .idx   (sect_idx),
    .map   (erase_map)
  );

  assign erase_start   = start_q;
  assign erase_chip    = chip_q;
  assign erase_busy    = (st == S_SECT_ERASE) || (st == S_CHIP_ERASE);
  assign timer_expired = (st == S_SECT_ERASE);
  assign suspend_req   = susp_q;
  assign bypass_mode   = byp;

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  p_start_has_work_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_busy && erase_map != '0));
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !erase_done) |=> erase_busy);
  p_chip_full_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_chip |-> (&erase_map));
  p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!erase_busy && !erase_start && erase_map == '0));
  p_expiry_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WINDOW && win_expired && !(wr_stb && wr_data != CMD_SUSPEND))
      |=> (erase_start && timer_expired));
  p_bypass_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(bypass_mode));

endmodule

// File: tb/tb_erase_cmd_seq.sv
module tb_erase_cmd_seq;
  localparam int W = 100;  // WIN_US=1 at 100 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        erase_done = 1'b0;
  logic        erase_start, erase_chip, erase_busy, timer_expired, suspend_req, bypass_mode;
  logic [63:0] erase_map;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  erase_cmd_seq #(.ADDR_W(18), .SECTORS(64), .WIN_US(1), .CLK_MHZ(100)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_done(erase_done), .erase_start(erase_start), .erase_map(erase_map),
    .erase_chip(erase_chip), .erase_busy(erase_busy), .timer_expired(timer_expired),
    .suspend_req(suspend_req), .bypass_mode(bypass_mode)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] sa(input int idx);
    return {idx[5:0], 12'h000};
  endfunction

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock2();
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
  endtask

  task automatic sect_norm(input int idx);
    unlock2(); wr(18'h555, 8'h80); unlock2(); wr(sa(idx), 8'h30);
  endtask

  task automatic finish_erase(input string req);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    check(req, "busy after done", erase_busy, 0);
    check(req, "map after done", erase_map, 0);
    check(req, "chip after done", erase_chip, 0);
    check(req, "expired after done", timer_expired, 0);
  endtask

  // waits for erase_start; returns the edge count at which it was seen
  task automatic wait_start(output int at);
    int guard = 0;
    while (!erase_start && guard < 4 * W) begin
      @(negedge clk); guard++;
    end
    at = erase_start ? cyc : -1;
  endtask

  task automatic t_reset();
    check("R1", "start", erase_start, 0);
    check("R1", "busy", erase_busy, 0);
    check("R1", "chip", erase_chip, 0);
    check("R1", "expired", timer_expired, 0);
    check("R1", "suspend", suspend_req, 0);
    check("R1", "bypass", bypass_mode, 0);
    check("R1", "map", erase_map, 0);
  endtask

  task automatic t_single();
    int t0, at;
    sect_norm(5);
    t0 = cyc;
    check("R11", "expired in window", timer_expired, 0);
    repeat (W - 1) @(negedge clk);
    check("R2", "no early start", erase_start, 0);
    @(negedge clk);
    check("R2", "start on time", erase_start, 1);
    check("R2", "one-hot map", erase_map, 64'h1 << 5);
    check("R11", "expired at start", timer_expired, 1);
    at = cyc;
    check("R2", "start edge", at - t0, W);
    @(negedge clk);
    check("R2", "start one cycle", erase_start, 0);
    check("R7", "busy held", erase_busy, 1);
    finish_erase("R7");
  endtask

  task automatic t_multi();
    int t1, at;
    sect_norm(3);
    repeat (50) @(negedge clk);
    wr(sa(60), 8'h30);
    t1 = cyc;
    wait_start(at);
    check("R3", "restart window", at - t1, W);
    check("R3", "two bits", erase_map, (64'h1 << 3) | (64'h1 << 60));
    // R7: commands ignored during sector erase
    unlock2();
    wr(sa(1), 8'h30);
    check("R7", "map unchanged", erase_map, (64'h1 << 3) | (64'h1 << 60));
    check("R7", "busy unchanged", erase_busy, 1);
    finish_erase("R7");
  endtask

  task automatic t_abort();
    int t0, at;
    bit seen = 0;
    sect_norm(7);
    wr(18'h555, 8'hF0);
    for (int i = 0; i < W + 10; i++) begin
      @(negedge clk);
      if (erase_start) seen = 1;
    end
    check("R4", "no start after abort", seen, 0);
    check("R4", "map cleared", erase_map, 0);
    check("R4", "not busy", erase_busy, 0);
    sect_norm(8);
    t0 = cyc;
    wait_start(at);
    check("R4", "new sequence accepted", at - t0, W);
    check("R4", "new map", erase_map, 64'h1 << 8);
    finish_erase("R4");
  endtask

  task automatic t_suspend();
    int t0, at;
    sect_norm(9);
    t0 = cyc;
    repeat (20) @(negedge clk);
    wr(18'h0, 8'hB0);
    check("R5", "suspend pulse", suspend_req, 1);
    @(negedge clk);
    check("R5", "suspend one cycle", suspend_req, 0);
    wait_start(at);
    check("R5", "window not restarted", at - t0, W);
    check("R5", "map kept", erase_map, 64'h1 << 9);
    @(negedge clk);
    wr(18'h0, 8'hB0);
    check("R5", "suspend during erase", suspend_req, 1);
    check("R5", "busy kept", erase_busy, 1);
    finish_erase("R5");
  endtask

  task automatic t_chip();
    unlock2(); wr(18'h555, 8'h80); unlock2(); wr(18'h555, 8'h10);
    check("R6", "chip start", erase_start, 1);
    check("R6", "chip flag", erase_chip, 1);
    check("R6", "full map", erase_map, '1);
    check("R11", "expired stays low", timer_expired, 0);
    wr(18'h0, 8'hB0);
    check("R7", "no suspend in chip erase", suspend_req, 0);
    sect_norm(2);
    check("R7", "chip busy held", erase_busy, 1);
    check("R7", "chip map held", erase_map, '1);
    finish_erase("R7");
  endtask

  task automatic t_mismatch();
    wr(18'h555, 8'hAA); wr(18'h2AA, 8'h54);
    wr(18'h555, 8'h80); unlock2(); wr(18'h555, 8'h10);
    repeat (2) @(negedge clk);
    check("R10", "no start after bad unlock", erase_busy, 0);
    wr(18'h554, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'h80); unlock2(); wr(18'h555, 8'h10);
    check("R10", "bad address rejected", erase_busy, 0);
    unlock2(); wr(18'h555, 8'h80); unlock2(); wr(18'h555, 8'h10);
    check("R10", "clean sequence works", erase_start, 1);
    finish_erase("R10");
  endtask

  task automatic t_bypass();
    int t0, at;
    unlock2(); wr(18'h555, 8'h20);
    check("R8", "bypass on", bypass_mode, 1);
    wr(18'h123, 8'h80); wr(18'h3FF, 8'h10);
    check("R8", "bypass chip start", erase_start, 1);
    check("R8", "bypass chip map", erase_map, '1);
    finish_erase("R8");
    check("R8", "bypass kept", bypass_mode, 1);
    wr(18'h0, 8'h80); unlock2(); wr(sa(12), 8'h30);
    t0 = cyc;
    wait_start(at);
    check("R8", "bypass sector timing", at - t0, W);
    check("R8", "bypass sector map", erase_map, 64'h1 << 12);
    finish_erase("R8");
    wr(18'h0, 8'h90); wr(18'h0, 8'h11);
    check("R9", "wrong exit keeps bypass", bypass_mode, 1);
    wr(18'h0, 8'h90); wr(18'h0, 8'h00);
    check("R9", "exit clears bypass", bypass_mode, 0);
    wr(18'h0, 8'h80); wr(18'h0, 8'h10);
    check("R9", "short chip erase refused", erase_busy, 0);
  endtask

  task automatic t_reset_mid();
    unlock2(); wr(18'h555, 8'h20);
    wr(18'h0, 8'h80); wr(18'h0, 8'h10);
    check("R12", "busy before reset", erase_busy, 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R12", "busy cleared", erase_busy, 0);
    check("R12", "map cleared", erase_map, 0);
    check("R12", "chip cleared", erase_chip, 0);
    check("R12", "bypass cleared", bypass_mode, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_multi();
    t_abort();
    t_suspend();
    t_chip();
    t_mismatch();
    t_bypass();
    t_reset_mid();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule